// File: doc/BRIEF.md
# Wait-State Bus Bridge for a Slow Byte-Wide Peripheral

This block sits between the external memory bus of a fast processor and a slow 8-bit parallel peripheral, such as a serial controller with eight internal registers. It watches each processor bus cycle. When the address falls inside the window assigned to the peripheral, it asserts an active-low chip select. It forwards the lowest address bits as a register selector. It then pulses an active-low read strobe or write strobe, depending on the direction line.

The peripheral needs its strobes to stay active for at least two cycles of its own clock. That is far longer than one processor cycle. The bridge therefore holds the processor's ready input low and so stretches the cycle. The stretch is computed at elaboration from the peripheral clock period, the number of peripheral cycles required, and the processor clock period, using a ceiling division. The default is a 1.8432 MHz peripheral clock and a 100 MHz processor clock, which gives 109 strobe cycles. Each access has one setup cycle, during which chip select and selector are valid before the strobe. It also has one hold cycle after the strobe. Cycles to any other address finish with no wait states.

Top module: `cpu_uart_bridge`

## Requirements
- R1: During an in-range access, `per_sel` equals bits 2:0 of the processor address latched at the start of the access, and it stays unchanged from the setup cycle through the hold cycle.
- R2: `per_cs_n` goes low only for addresses whose bits 15:3 equal bits 15:3 of `BASE_ADDR` (default 16'h8000). Any other address leaves `per_cs_n`, `per_rd_n` and `per_wr_n` high.
- R3: When `cpu_rw` is 1 (read), only `per_rd_n` pulses. When `cpu_rw` is 0 (write), only `per_wr_n` pulses. The two strobes are never low in the same cycle.
- R4: For an in-range access, `cpu_rdy` is low from the first cycle in which `cpu_strb_n` is low until the last strobe cycle, when it goes high. This gives exactly W+1 cycles with `cpu_rdy` low.
- R5: Each strobe stays low for exactly W consecutive processor cycles, with W = ceil(PER_CLKS × PER_CLK_PS / CPU_CLK_PS). The default W is 109.
- R6: `per_cs_n` is low for one full cycle before the strobe falls, and it stays low for one cycle after the strobe rises.
- R7: `cpu_rdata_oe` is high only while `per_rd_n` is low. During that time `cpu_rdata` equals `per_rdata`.
- R8: `per_wdata_oe` is high in every cycle in which `per_wr_n` is low. During that time `per_wdata` equals the processor's write data.
- R9: A cycle to an address outside the window keeps `cpu_rdy` high throughout and completes with zero wait states.
- R10: While `rst` is high, and in the cycle after it is sampled, both strobes and `per_cs_n` are high. `cpu_rdy` is high while `rst` is high.
- R11: Keeping `cpu_strb_n` low after an access has completed does not start a second access. Chip select and the strobes stay high until `cpu_strb_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Processor address |
| cpu_rw | input | 1 | Direction: 1 read, 0 write |
| cpu_strb_n | input | 1 | Active-low bus cycle strobe from the processor |
| cpu_wdata | input | 8 | Write data from the processor |
| cpu_rdata | output | 8 | Read data toward the processor |
| cpu_rdata_oe | output | 1 | Enable for driving read data onto the processor bus |
| cpu_rdy | output | 1 | Ready to the processor; low inserts wait states |
| per_sel | output | 3 | Register selector to the peripheral |
| per_cs_n | output | 1 | Active-low peripheral chip select |
| per_rd_n | output | 1 | Active-low read strobe |
| per_wr_n | output | 1 | Active-low write strobe |
| per_wdata | output | 8 | Write data toward the peripheral |
| per_wdata_oe | output | 1 | Enable for driving write data onto the peripheral bus |
| per_rdata | input | 8 | Read data from the peripheral |

## Verification
A sequencer left in the wrong state shows up at the ports within one cycle. It can appear as a strobe with no setup cycle, chip select released together with the strobe, or ready going high while the strobe is still short. Any of these changes the counted setup, hold or wait cycles of that same access. An error in the down-counter load or its terminal detection changes the strobe width from W. The bench counts the width cycle by cycle, so it sees the error when the strobe rises. A stuck decode or a latch that retriggers shows up as chip select activity on an out-of-range cycle or during a held strobe, within a few cycles.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

  typedef enum logic [2:0] {
    UBR_IDLE   = 3'd0,
    UBR_SETUP  = 3'd1,
    UBR_STROBE = 3'd2,
    UBR_HOLD   = 3'd3,
    UBR_DONE   = 3'd4
  } ubr_state_t;

  // Processor cycles needed to cover the peripheral's minimum strobe width.
  function automatic int unsigned ubr_wait_cycles(input int unsigned per_clk_ps,
                                                  input int unsigned per_clks,
                                                  input int unsigned cpu_clk_ps);
    int unsigned span;
    span = per_clk_ps * per_clks;
    return (span + cpu_clk_ps - 1) / cpu_clk_ps;
  endfunction

  // Counter width able to hold values up to n-1 (at least one bit).
  function automatic int unsigned ubr_cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ubr_addr_decode.sv
module ubr_addr_decode #(
  parameter int ADDR_W = 16,
  parameter int SEL_W = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - SEL_W;

  generate
    if (TAG_W > 0) begin : g_tag
      logic [TAG_W-1:0] tag_in;
      logic [TAG_W-1:0] tag_base;
      assign tag_in   = cpu_addr[ADDR_W-1:SEL_W];
      assign tag_base = BASE_ADDR[ADDR_W-1:SEL_W];
      assign hit      = (tag_in == tag_base);
    end else begin : g_all
      assign hit = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ubr_wait_counter.sv
module ubr_wait_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (en && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ubr_seq.sv
module ubr_seq
  import ubr_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W = 7,
  parameter int unsigned WAIT_CYCLES = 109
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              strb_on,
  input  logic              cnt_zero,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              rw_in,
  input  logic [DATA_W-1:0] wdata_in,
  output ubr_state_t        state,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_val,
  output logic [SEL_W-1:0]  sel_q,
  output logic              rw_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= UBR_IDLE;
      sel_q   <= '0;
      rw_q    <= 1'b1;
      wdata_q <= '0;
    end else begin
      case (state)
        UBR_IDLE: begin
          if (req) begin
            state   <= UBR_SETUP;
            sel_q   <= sel_in;
            rw_q    <= rw_in;
            wdata_q <= wdata_in;
          end
        end
        UBR_SETUP:  state <= UBR_STROBE;
        UBR_STROBE: if (cnt_zero) state <= UBR_HOLD;
        UBR_HOLD:   state <= strb_on ? UBR_DONE : UBR_IDLE;
        UBR_DONE:   if (!strb_on) state <= UBR_IDLE;
        default:    state <= UBR_IDLE;
      endcase
    end
  end

  assign cnt_load = (state == UBR_SETUP);
  assign cnt_val  = CNT_W'(WAIT_CYCLES - 1);
endmodule

// File: rtl/cpu_uart_bridge.sv
module cpu_uart_bridge
  import ubr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  parameter int unsigned CPU_CLK_PS = 10000,
  parameter int unsigned PER_CLK_PS = 542535,
  parameter int unsigned PER_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_strb_n,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic              cpu_rdy,
  output logic [SEL_W-1:0]  per_sel,
  output logic              per_cs_n,
  output logic              per_rd_n,
  output logic              per_wr_n,
  output logic [DATA_W-1:0] per_wdata,
  output logic              per_wdata_oe,
  input  logic [DATA_W-1:0] per_rdata
);
  localparam int unsigned WAIT_CYCLES = ubr_wait_cycles(PER_CLK_PS, PER_CLKS, CPU_CLK_PS);
  localparam int CNT_W = int'(ubr_cnt_width(WAIT_CYCLES));

  // Named internal events, visible to the bound checker.
  logic        addr_hit;
  logic        access_req;
  logic        seq_idle;
  logic        in_setup;
  logic        in_strobe;
  logic        in_hold;
  logic        cnt_zero;
  logic        cnt_load;
  logic [CNT_W-1:0] cnt_val;
  ubr_state_t  state;
  logic        rw_q;

  ubr_addr_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASE_ADDR(BASE_ADDR)
  ) dec_i (
    .cpu_addr(cpu_addr),
    .hit     (addr_hit)
  );

  assign access_req = !cpu_strb_n && addr_hit;

  ubr_seq #(
    .SEL_W(SEL_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WAIT_CYCLES(WAIT_CYCLES)
  ) seq_i (
    .clk     (clk),
    .rst     (rst),
    .req     (access_req),
    .strb_on (!cpu_strb_n),
    .cnt_zero(cnt_zero),
    .sel_in  (cpu_addr[SEL_W-1:0]),
    .rw_in   (cpu_rw),
    .wdata_in(cpu_wdata),
    .state   (state),
    .cnt_load(cnt_load),
    .cnt_val (cnt_val),
    .sel_q   (per_sel),
    .rw_q    (rw_q),
    .wdata_q (per_wdata)
  );

  ubr_wait_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(cnt_val),
    .en      (in_strobe),
    .zero    (cnt_zero)
  );

  assign seq_idle  = (state == UBR_IDLE);
  assign in_setup  = (state == UBR_SETUP);
  assign in_strobe = (state == UBR_STROBE);
  assign in_hold   = (state == UBR_HOLD);

  assign per_cs_n = !(in_setup || in_strobe || in_hold);
  assign per_rd_n = !(in_strobe && rw_q);
  assign per_wr_n = !(in_strobe && !rw_q);

  assign per_wdata_oe = !rw_q && !per_cs_n;
  assign cpu_rdata_oe = in_strobe && rw_q;
  assign cpu_rdata    = cpu_rdata_oe ? per_rdata : '0;

  // Ready drops on the very first cycle of an in-range access and rises on the last strobe cycle.
  assign cpu_rdy = rst || !((seq_idle && access_req) || in_setup || (in_strobe && !cnt_zero));
endmodule

// File: rtl/ubr_checker.sv
module ubr_checker #(
  parameter int unsigned WAIT_CYCLES = 109
) (
  input logic       clk,
  input logic       rst,
  input logic       cpu_strb_n,
  input logic       cpu_rdy,
  input logic       cpu_rdata_oe,
  input logic [2:0] per_sel,
  input logic       per_cs_n,
  input logic       per_rd_n,
  input logic       per_wr_n,
  input logic       per_wdata_oe,
  input logic       addr_hit,
  input logic       seq_idle
);
  logic        strobe_low;
  logic        prev_low;
  logic [15:0] width_cnt;

  assign strobe_low = !per_rd_n || !per_wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_low  <= 1'b0;
      width_cnt <= '0;
    end else begin
      prev_low  <= strobe_low;
      width_cnt <= strobe_low ? width_cnt + 1'b1 : '0;
    end
  end

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(!per_rd_n && !per_wr_n));

  assert_strobe_needs_cs_R2: assert property (@(posedge clk) disable iff (rst)
    strobe_low |-> !per_cs_n);

  assert_setup_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe_low && !prev_low) |-> $past(!per_cs_n));

  assert_hold_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (prev_low && !strobe_low) |-> !per_cs_n);

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
    (prev_low && !strobe_low) |-> (width_cnt == 16'(WAIT_CYCLES)));

  assert_sel_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (strobe_low && prev_low) |-> $stable(per_sel));

  assert_read_drive_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata_oe |-> !per_rd_n);

  assert_write_drive_R8: assert property (@(posedge clk) disable iff (rst)
    !per_wr_n |-> per_wdata_oe);

  assert_miss_no_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (!cpu_strb_n && !addr_hit && seq_idle) |-> cpu_rdy);

  assert_rdy_low_in_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe_low && prev_low && !cpu_rdy) |-> $past(!cpu_rdy));

  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (per_cs_n && per_rd_n && per_wr_n));
endmodule

bind cpu_uart_bridge ubr_checker #(.WAIT_CYCLES(WAIT_CYCLES)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cpu_strb_n  (cpu_strb_n),
  .cpu_rdy     (cpu_rdy),
  .cpu_rdata_oe(cpu_rdata_oe),
  .per_sel     (per_sel),
  .per_cs_n    (per_cs_n),
  .per_rd_n    (per_rd_n),
  .per_wr_n    (per_wr_n),
  .per_wdata_oe(per_wdata_oe),
  .addr_hit    (addr_hit),
  .seq_idle    (seq_idle)
);

// File: tb/cpu_uart_bridge_tb.sv
`timescale 1ns/1ps
module cpu_uart_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rw = 1'b1;
  logic        cpu_strb_n = 1'b1;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_oe;
  logic        cpu_rdy;
  logic [2:0]  per_sel;
  logic        per_cs_n;
  logic        per_rd_n;
  logic        per_wr_n;
  logic [7:0]  per_wdata;
  logic        per_wdata_oe;
  logic [7:0]  per_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int exp_w;

  always #5 clk = ~clk;

  cpu_uart_bridge dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_strb_n(cpu_strb_n), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rdata_oe(cpu_rdata_oe), .cpu_rdy(cpu_rdy), .per_sel(per_sel),
    .per_cs_n(per_cs_n), .per_rd_n(per_rd_n), .per_wr_n(per_wr_n),
    .per_wdata(per_wdata), .per_wdata_oe(per_wdata_oe), .per_rdata(per_rdata)
  );

  // Vector fields: addr[33:18] rw[17] wdata[16:9] rdata[8:1] in_range[0]
  localparam logic [33:0] VECS [6] = '{
    {16'h8005, 1'b1, 8'h00, 8'hA5, 1'b1},
    {16'h8003, 1'b0, 8'h3C, 8'h00, 1'b1},
    {16'h8000, 1'b0, 8'hFF, 8'h00, 1'b1},
    {16'h8007, 1'b1, 8'h00, 8'h5A, 1'b1},
    {16'h8008, 1'b1, 8'h00, 8'h77, 1'b0},
    {16'h7FFF, 1'b0, 8'h12, 8'h00, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_access(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                           input logic [7:0] rd, input logic hit, input bit hold_low);
    int waits = 0, strobe_cyc = 0, setup_cyc = 0, wrong_kind = 0;
    int sel_bad = 0, rd_bad = 0, wr_bad = 0, cs_miss = 0, both = 0;
    bit done = 0;
    @(posedge clk); #2;
    cpu_addr = a; cpu_rw = rw; cpu_wdata = wd; per_rdata = rd; cpu_strb_n = 1'b0;
    for (int g = 0; g < 1000 && !done; g++) begin
      @(negedge clk);
      if (!cpu_rdy) waits++;
      if (!per_rd_n && !per_wr_n) both++;
      if (!per_cs_n && per_rd_n && per_wr_n && strobe_cyc == 0) setup_cyc++;
      if (!hit && !per_cs_n) cs_miss++;
      if (!per_rd_n || !per_wr_n) begin
        strobe_cyc++;
        if (per_sel != a[2:0]) sel_bad++;
        if ((rw && !per_wr_n) || (!rw && !per_rd_n)) wrong_kind++;
        if (rw && (!cpu_rdata_oe || cpu_rdata != rd)) rd_bad++;
        if (!rw && (!per_wdata_oe || per_wdata != wd)) wr_bad++;
      end
      if (cpu_rdy) done = 1;
    end
    if (hit) begin
      check(waits == exp_w + 1, "R4 wait cycles", waits, exp_w + 1);
      check(strobe_cyc == exp_w, "R5 strobe width", strobe_cyc, exp_w);
      check(setup_cyc == 1, "R6 setup cycle", setup_cyc, 1);
      check(sel_bad == 0, "R1 selector", sel_bad, 0);
      check(wrong_kind == 0 && both == 0, "R3 strobe kind", wrong_kind + both, 0);
      if (rw) check(rd_bad == 0, "R7 read data", rd_bad, 0);
      else    check(wr_bad == 0, "R8 write data", wr_bad, 0);
    end else begin
      check(waits == 0, "R9 zero waits", waits, 0);
      check(cs_miss == 0 && strobe_cyc == 0, "R2 no select out of range", cs_miss + strobe_cyc, 0);
    end
    @(posedge clk); #2;
    if (!hold_low) cpu_strb_n = 1'b1;
    @(negedge clk);
    if (hit) begin
      check(!per_cs_n && per_rd_n && per_wr_n, "R6 hold cycle", per_cs_n, 0);
      check(per_sel == a[2:0], "R1 selector hold", per_sel, a[2:0]);
      check(!cpu_rdata_oe, "R7 no drive after strobe", cpu_rdata_oe, 0);
    end
    if (hold_low) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(per_cs_n && per_rd_n && per_wr_n && cpu_rdy, "R11 no retrigger",
              {per_cs_n, per_rd_n, per_wr_n, cpu_rdy}, 4'hF);
      end
      @(posedge clk); #2;
      cpu_strb_n = 1'b1;
    end
    @(negedge clk);
    check(per_cs_n, "R2 select released", per_cs_n, 1);
  endtask

  initial begin
    exp_w = int'($ceil(2.0 * (1.0e9 / 1843200.0) / 10.0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(per_cs_n && per_rd_n && per_wr_n && cpu_rdy, "R10 reset state",
          {per_cs_n, per_rd_n, per_wr_n, cpu_rdy}, 4'hF);
    @(posedge clk); #2;
    rst = 1'b0;

    for (int i = 0; i < 6; i++) begin
      do_access(VECS[i][33:18], VECS[i][17], VECS[i][16:9], VECS[i][8:1], VECS[i][0], 1'b0);
    end

    // R11: strobe held low after completion
    do_access(16'h8002, 1'b1, 8'h00, 8'hC3, 1'b1, 1'b1);

    // R10: reset in the middle of a strobe
    @(posedge clk); #2;
    cpu_addr = 16'h8004; cpu_rw = 1'b0; cpu_wdata = 8'h99; cpu_strb_n = 1'b0;
    repeat (10) @(negedge clk);
    check(!per_wr_n, "R3 write strobe active", per_wr_n, 0);
    @(posedge clk); #2;
    rst = 1'b1;
    @(negedge clk);
    check(cpu_rdy, "R10 ready under reset", cpu_rdy, 1);
    @(negedge clk);
    check(per_cs_n && per_rd_n && per_wr_n, "R10 strobes cleared",
          {per_cs_n, per_rd_n, per_wr_n}, 3'h7);
    @(posedge clk); #2;
    cpu_strb_n = 1'b1; rst = 1'b0;
    @(negedge clk);
    check(per_cs_n && cpu_rdy, "R10 idle after reset", {per_cs_n, cpu_rdy}, 2'h3);

    // Back-to-back after reset still works
    do_access(16'h8006, 1'b1, 8'h00, 8'h81, 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule